// File: doc/BRIEF.md
# TLB Entry Permission Checker

This block judges one access against a paired translation entry that has already been found by the lookup logic. The entry carries two page words, one for the even page and one for the odd page of a pair. The block picks the word that covers the virtual address and works through the access-rights checks in a fixed priority. It returns a 3-bit result code. When every check passes it also returns the physical address and the read, write and execute grants.

Two entry formats are supported, selected per request: a 64-bit format and a 32-bit format. The 32-bit format has no no-read, no-execute or restricted-privilege bits. The page-size shift comes with each request. The page-number bits that lie inside the page are treated as software-owned and are masked off before the physical address is formed.

All inputs are sampled on one clock edge, and the registered results appear after that edge.

Top module: `tlb_perm_check`

## Requirements
- R1: The odd-page word is used when virtual address bit [ps] is 1; otherwise the even-page word is used. Here ps is the effective page shift.
- R2: Entry layout: bit 0 valid, bit 1 dirty, bits 3:2 entry privilege level. The page number starts at bit 12. In 64-bit mode bit 61 is no-read, bit 62 is no-execute and bit 63 is restricted-privilege. Access codes are fetch=0, load=1 and store=2. Code 3 is subject only to the valid and privilege checks.
- R3: Checks are made in priority order, and only the first failure is reported. Result codes are MATCH=0, INVALID=1, XI=2, RI=3, PE=4 and DIRTY=5.
  - An entry that is not valid gives INVALID.
  - A fetch with no-execute set gives XI.
  - A load with no-read set gives RI.
  - A privilege failure gives PE.
  - A store with dirty clear gives DIRTY.
  - Otherwise the result is MATCH.
- R4: Restricted-privilege clear: a privilege failure means the current level is numerically greater than the entry level. Restricted-privilege set: a privilege failure means the two levels differ.
- R5: With mode64=0, the no-execute, no-read and restricted-privilege bits are taken as zero. The page number comes from entry bits 31:12 only, and entry bits 63:32 have no effect.
- R6: Page-number bits that map to address bits 12 through ps-1 are cleared before use.
- R7: On MATCH, the physical address is the masked page number shifted left by 12, OR'd with the low ps bits of the virtual address.
- R8: On MATCH, read is always granted. Write is granted only when dirty is set. Execute is granted only when no-execute is clear.
- R9: When the result is not MATCH, the physical address and all three grants are zero.
- R10: A page shift below 12 is treated as 12, and one above 30 is treated as 30.
- R11: Results appear one clock edge after the inputs are sampled. While reset is active, the result is INVALID and the address and grants are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode64 | input | 1 | 1 selects the 64-bit entry format, 0 the 32-bit format |
| entry_even | input | 64 | Even-page word of the entry pair |
| entry_odd | input | 64 | Odd-page word of the entry pair |
| page_shift | input | 5 | Page-size shift (log2 of page bytes) |
| vaddr | input | VA_W | Virtual address of the access |
| access | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| cur_plv | input | 2 | Current privilege level |
| result | output | 3 | Result code |
| paddr | output | PA_W | Physical address, valid on MATCH |
| grant_r | output | 1 | Read permission granted |
| grant_w | output | 1 | Write permission granted |
| grant_x | output | 1 | Execute permission granted |

## Verification
The bench builds the block with its default parameters: a 64-bit virtual address, a 48-bit physical address and a page shift range of 12 to 30. These values give a 36-bit page number, so both ends of the page-size range can be reached. At the top end, the page-number mask clears 18 bits, and the odd/even choice moves to address bit 30. Page shifts outside the range, such as 5 and 31, are also driven to exercise the clamp. Each fault is paired with a lower-priority fault in the same entry, which confirms the order of the checks.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;

    typedef enum logic [2:0] {
        RES_MATCH   = 3'd0,
        RES_INVALID = 3'd1,
        RES_NOEXEC  = 3'd2,
        RES_NOREAD  = 3'd3,
        RES_PRIV    = 3'd4,
        RES_DIRTY   = 3'd5
    } result_e;

    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_LOAD  = 2'd1;
    localparam logic [1:0] ACC_STORE = 2'd2;

    localparam int PAGE_BASE = 12;
    localparam int PS_W      = 5;
    localparam int PLV_W     = 2;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [PLV_W-1:0] plv;
        logic             noread;
        logic             noexec;
        logic             rplv;
    } pte_flags_t;

endpackage

// File: rtl/tlbchk_field_sel.sv
module tlbchk_field_sel
    import tlbchk_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int PA_W   = 48,
    parameter int PS_MIN = 12,
    parameter int PS_MAX = 30,
    localparam int PPN_W = PA_W - PAGE_BASE
) (
    input  logic             mode64,
    input  logic [63:0]      entry_even,
    input  logic [63:0]      entry_odd,
    input  logic [PS_W-1:0]  page_shift,
    input  logic [VA_W-1:0]  vaddr,
    output logic [PS_W-1:0]  ps_eff,
    output pte_flags_t       flags,
    output logic [PPN_W-1:0] ppn
);

    logic [63:0] word;

    always_comb begin
        if (page_shift < PS_W'(PS_MIN)) begin
            ps_eff = PS_W'(PS_MIN);
        end else if (page_shift > PS_W'(PS_MAX)) begin
            ps_eff = PS_W'(PS_MAX);
        end else begin
            ps_eff = page_shift;
        end
    end

    always_comb begin
        word         = vaddr[ps_eff] ? entry_odd : entry_even;
        flags.valid  = word[0];
        flags.dirty  = word[1];
        flags.plv    = word[3:2];
        if (mode64) begin
            flags.noread = word[61];
            flags.noexec = word[62];
            flags.rplv   = word[63];
            ppn          = word[PA_W-1:PAGE_BASE];
        end else begin
            flags.noread = 1'b0;
            flags.noexec = 1'b0;
            flags.rplv   = 1'b0;
            ppn          = PPN_W'(word[31:PAGE_BASE]);
        end
    end

endmodule

// File: rtl/tlbchk_rights.sv
module tlbchk_rights
    import tlbchk_pkg::*;
(
    input  pte_flags_t       flags,
    input  logic [1:0]       access,
    input  logic [PLV_W-1:0] cur_plv,
    output result_e          res
);

    logic priv_fail;

    always_comb begin
        if (flags.rplv) begin
            priv_fail = (cur_plv != flags.plv);
        end else begin
            priv_fail = (cur_plv > flags.plv);
        end
    end

    always_comb begin
        if (!flags.valid) begin
            res = RES_INVALID;
        end else if (access == ACC_FETCH && flags.noexec) begin
            res = RES_NOEXEC;
        end else if (access == ACC_LOAD && flags.noread) begin
            res = RES_NOREAD;
        end else if (priv_fail) begin
            res = RES_PRIV;
        end else if (access == ACC_STORE && !flags.dirty) begin
            res = RES_DIRTY;
        end else begin
            res = RES_MATCH;
        end
    end

endmodule

// File: rtl/tlbchk_addr.sv
module tlbchk_addr
    import tlbchk_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int PA_W = 48,
    localparam int PPN_W = PA_W - PAGE_BASE
) (
    input  logic [PPN_W-1:0] ppn,
    input  logic [PS_W-1:0]  ps_eff,
    input  logic [VA_W-1:0]  vaddr,
    output logic [PA_W-1:0]  paddr
);

    logic [PS_W-1:0]  sw_bits;
    logic [PPN_W-1:0] sw_mask;
    logic [PPN_W-1:0] ppn_clean;
    logic [PA_W-1:0]  off_mask;

    always_comb begin
        sw_bits   = ps_eff - PS_W'(PAGE_BASE);
        sw_mask   = (PPN_W'(1) << sw_bits) - PPN_W'(1);
        ppn_clean = ppn & ~sw_mask;
        off_mask  = (PA_W'(1) << ps_eff) - PA_W'(1);
        paddr     = {ppn_clean, {PAGE_BASE{1'b0}}} | (vaddr[PA_W-1:0] & off_mask);
    end

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
    import tlbchk_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int PA_W   = 48,
    parameter int PS_MIN = 12,
    parameter int PS_MAX = 30,
    localparam int PPN_W = PA_W - PAGE_BASE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode64,
    input  logic [63:0]      entry_even,
    input  logic [63:0]      entry_odd,
    input  logic [PS_W-1:0]  page_shift,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [1:0]       access,
    input  logic [PLV_W-1:0] cur_plv,
    output logic [2:0]       result,
    output logic [PA_W-1:0]  paddr,
    output logic             grant_r,
    output logic             grant_w,
    output logic             grant_x
);

    typedef struct packed {
        result_e         res;
        logic [PA_W-1:0] pa;
        logic            r;
        logic            w;
        logic            x;
    } out_t;

    logic [PS_W-1:0]  ps_eff;
    pte_flags_t       flags;
    logic [PPN_W-1:0] ppn;
    result_e          chk_res;
    logic [PA_W-1:0]  pa_raw;
    out_t             out_d;
    out_t             out_q;

    tlbchk_field_sel #(
        .VA_W  (VA_W),
        .PA_W  (PA_W),
        .PS_MIN(PS_MIN),
        .PS_MAX(PS_MAX)
    ) u_sel (
        .mode64    (mode64),
        .entry_even(entry_even),
        .entry_odd (entry_odd),
        .page_shift(page_shift),
        .vaddr     (vaddr),
        .ps_eff    (ps_eff),
        .flags     (flags),
        .ppn       (ppn)
    );

    tlbchk_rights u_rights (
        .flags  (flags),
        .access (access),
        .cur_plv(cur_plv),
        .res    (chk_res)
    );

    tlbchk_addr #(
        .VA_W(VA_W),
        .PA_W(PA_W)
    ) u_addr (
        .ppn   (ppn),
        .ps_eff(ps_eff),
        .vaddr (vaddr),
        .paddr (pa_raw)
    );

    always_comb begin
        out_d.res = chk_res;
        if (chk_res == RES_MATCH) begin
            out_d.pa = pa_raw;
            out_d.r  = 1'b1;
            out_d.w  = flags.dirty;
            out_d.x  = !flags.noexec;
        end else begin
            out_d.pa = '0;
            out_d.r  = 1'b0;
            out_d.w  = 1'b0;
            out_d.x  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.res <= RES_INVALID;
            out_q.pa  <= '0;
            out_q.r   <= 1'b0;
            out_q.w   <= 1'b0;
            out_q.x   <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result  = out_q.res;
    assign paddr   = out_q.pa;
    assign grant_r = out_q.r;
    assign grant_w = out_q.w;
    assign grant_x = out_q.x;

endmodule

// File: rtl/tlb_perm_check_chk.sv
module tlb_perm_check_chk #(
    parameter int VA_W = 64,
    parameter int PA_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mode64,
    input logic [VA_W-1:0] vaddr,
    input logic [1:0]      access,
    input logic [2:0]      result,
    input logic [PA_W-1:0] paddr,
    input logic            grant_r,
    input logic            grant_w,
    input logic            grant_x
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R3
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result <= 3'd5);

    // R8
    match_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result == 3'd0) |-> grant_r);

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result != 3'd0) |-> (paddr == '0 && !grant_r && !grant_w && !grant_x));

    // R7
    page_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && result == 3'd0) |-> (paddr[11:0] == $past(vaddr[11:0])));

    // R5
    narrow_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(mode64) && result == 3'd0) |-> grant_x);

    // R5
    narrow_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(mode64)) |-> (result != 3'd2 && result != 3'd3));

    // R3
    fetch_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(access) == 2'd0) |-> (result != 3'd3 && result != 3'd5));

    // R8
    store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(access) == 2'd2 && result == 3'd0) |-> grant_w);

endmodule

bind tlb_perm_check tlb_perm_check_chk #(
    .VA_W(VA_W),
    .PA_W(PA_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode64 (mode64),
    .vaddr  (vaddr),
    .access (access),
    .result (result),
    .paddr  (paddr),
    .grant_r(grant_r),
    .grant_w(grant_w),
    .grant_x(grant_x)
);

// File: tb/tlb_perm_check_tb.sv
module tlb_perm_check_tb;

    localparam int VA_W = 64;
    localparam int PA_W = 48;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode64 = 1'b1;
    logic [63:0]     entry_even = '0;
    logic [63:0]     entry_odd = '0;
    logic [4:0]      page_shift = 5'd12;
    logic [VA_W-1:0] vaddr = '0;
    logic [1:0]      access = 2'd1;
    logic [1:0]      cur_plv = 2'd0;
    logic [2:0]      result;
    logic [PA_W-1:0] paddr;
    logic            grant_r, grant_w, grant_x;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tlb_perm_check #(.VA_W(VA_W), .PA_W(PA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode64(mode64),
        .entry_even(entry_even), .entry_odd(entry_odd),
        .page_shift(page_shift), .vaddr(vaddr), .access(access),
        .cur_plv(cur_plv), .result(result), .paddr(paddr),
        .grant_r(grant_r), .grant_w(grant_w), .grant_x(grant_x)
    );

    function automatic logic [63:0] mk(input bit v, input bit d, input logic [1:0] plv,
                                       input logic [35:0] ppn, input bit nr,
                                       input bit nx, input bit rp);
        logic [63:0] e;
        e = '0;
        e[0] = v; e[1] = d; e[3:2] = plv;
        e[47:12] = ppn;
        e[61] = nr; e[62] = nx; e[63] = rp;
        return e;
    endfunction

    task automatic apply(input bit m64, input logic [63:0] ev, input logic [63:0] od,
                         input logic [4:0] ps, input logic [63:0] va,
                         input logic [1:0] acc, input logic [1:0] plv);
        mode64 = m64; entry_even = ev; entry_odd = od; page_shift = ps;
        vaddr = va; access = acc; cur_plv = plv;
        @(posedge clk);
        #2;
    endtask

    task automatic expect_out(input string req, input logic [2:0] er,
                              input logic [PA_W-1:0] ep, input logic [2:0] erwx);
        checks++;
        if (result !== er || paddr !== ep || {grant_r, grant_w, grant_x} !== erwx) begin
            errors++;
            $display("FAIL %s: got res=%0d pa=%h rwx=%b, expected res=%0d pa=%h rwx=%b",
                     req, result, paddr, {grant_r, grant_w, grant_x}, er, ep, erwx);
        end
    endtask

    task automatic t_reset();
        expect_out("R11 reset", 3'd1, '0, 3'b000);
    endtask

    task automatic t_select();
        logic [63:0] ev, od;
        ev = mk(1, 1, 0, 36'h111, 0, 0, 0);
        od = mk(1, 1, 0, 36'h222, 0, 0, 0);
        apply(1, ev, od, 12, 64'h0ABC, 2'd1, 0);
        expect_out("R1 even word", 3'd0, 48'h111ABC, 3'b111);
        apply(1, ev, od, 12, 64'h1ABC, 2'd1, 0);
        expect_out("R1 odd word", 3'd0, 48'h222ABC, 3'b111);
    endtask

    task automatic t_priority();
        apply(1, mk(0, 0, 0, 36'h5, 1, 1, 0), '0, 12, 64'h0, 2'd0, 3);
        expect_out("R3 invalid first", 3'd1, '0, 3'b000);
        apply(1, mk(1, 0, 0, 36'h5, 1, 1, 0), '0, 12, 64'h0, 2'd0, 3);
        expect_out("R3 XI over PE", 3'd2, '0, 3'b000);
        apply(1, mk(1, 0, 0, 36'h5, 1, 1, 0), '0, 12, 64'h0, 2'd1, 3);
        expect_out("R3 RI over PE", 3'd3, '0, 3'b000);
        apply(1, mk(1, 0, 0, 36'h5, 1, 0, 0), '0, 12, 64'h10, 2'd0, 0);
        expect_out("R3 no-read ignored on fetch", 3'd0, 48'h5010, 3'b101);
        apply(1, mk(1, 0, 1, 36'h5, 0, 0, 0), '0, 12, 64'h0, 2'd2, 2);
        expect_out("R3 PE over DIRTY", 3'd4, '0, 3'b000);
        apply(1, mk(1, 0, 1, 36'h5, 0, 0, 0), '0, 12, 64'h0, 2'd2, 1);
        expect_out("R3 DIRTY on clean store", 3'd5, '0, 3'b000);
        apply(1, mk(1, 0, 1, 36'h5, 0, 1, 0), '0, 12, 64'h0, 2'd3, 1);
        expect_out("R2 code 3 skips fetch/store checks", 3'd0, 48'h5000, 3'b100);
    endtask

    task automatic t_priv();
        apply(1, mk(1, 1, 2, 36'h7, 0, 0, 0), '0, 12, 64'h4, 2'd1, 0);
        expect_out("R4 lower level allowed", 3'd0, 48'h7004, 3'b111);
        apply(1, mk(1, 1, 2, 36'h7, 0, 0, 0), '0, 12, 64'h4, 2'd1, 3);
        expect_out("R4 higher level PE", 3'd4, '0, 3'b000);
        apply(1, mk(1, 1, 2, 36'h7, 0, 0, 1), '0, 12, 64'h4, 2'd1, 0);
        expect_out("R4 restricted lower level PE", 3'd4, '0, 3'b000);
        apply(1, mk(1, 1, 2, 36'h7, 0, 0, 1), '0, 12, 64'h4, 2'd1, 2);
        expect_out("R4 restricted equal level", 3'd0, 48'h7004, 3'b111);
    endtask

    task automatic t_narrow();
        logic [63:0] e;
        e = 64'hFFFF_FFFF_0004_5003;
        apply(0, e, '0, 12, 64'h123, 2'd0, 0);
        expect_out("R5 narrow fetch ignores high bits", 3'd0, 48'h45123, 3'b111);
        apply(0, e, '0, 12, 64'h123, 2'd1, 0);
        expect_out("R5 narrow load ignores no-read", 3'd0, 48'h45123, 3'b111);
        apply(0, e, '0, 12, 64'h123, 2'd1, 1);
        expect_out("R5 narrow restricted bit forced off", 3'd4, '0, 3'b000);
        apply(1, e, '0, 12, 64'h123, 2'd0, 0);
        expect_out("R5 wide mode honours no-execute", 3'd2, '0, 3'b000);
    endtask

    task automatic t_mask();
        logic [35:0] p;
        logic [63:0] va;
        logic [47:0] exp_pa;
        apply(1, mk(1, 1, 0, 36'h12345, 0, 0, 0), '0, 21, 64'h000A_BCDE, 2'd2, 0);
        expect_out("R6 R7 ps=21 mask", 3'd0, 48'h122A_BCDE, 3'b111);
        p = 36'h9_8765_4321;
        va = 64'h7FFF_F123;
        exp_pa = ({p, 12'h000} & ~48'h3FFF_FFFF) | (va[47:0] & 48'h3FFF_FFFF);
        apply(1, mk(0, 0, 0, 36'h0, 0, 0, 0), mk(1, 0, 0, p, 0, 1, 0), 30, va, 2'd1, 0);
        expect_out("R6 R7 R8 ps=30 odd", 3'd0, exp_pa, 3'b100);
    endtask

    task automatic t_clamp();
        logic [63:0] ev, od;
        ev = mk(1, 1, 0, 36'h111, 0, 0, 0);
        od = mk(1, 1, 0, 36'h222, 0, 0, 0);
        apply(1, ev, od, 5, 64'h1000, 2'd1, 0);
        expect_out("R10 small shift clamps to 12", 3'd0, 48'h222000, 3'b111);
        apply(1, mk(0, 0, 0, 36'h0, 0, 0, 0), od, 31, 64'h4000_0ABC, 2'd1, 0);
        expect_out("R10 large shift clamps to 30", 3'd0, 48'h0ABC, 3'b111);
    endtask

    task automatic t_latency();
        apply(1, mk(1, 1, 0, 36'h33, 0, 0, 0), '0, 12, 64'h9, 2'd1, 0);
        entry_even = mk(0, 0, 0, 36'h0, 0, 0, 0);
        #2;
        expect_out("R11 held until next edge", 3'd0, 48'h33009, 3'b111);
        @(posedge clk);
        #2;
        expect_out("R9 R11 miss after edge", 3'd1, '0, 3'b000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        rst_n = 1'b1;
        t_select();
        t_priority();
        t_priv();
        t_narrow();
        t_mask();
        t_clamp();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule